// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and the calendar date in packed BCD registers. The time fields are seconds, minutes and hours. The date fields are day of month, month and a two-digit year. A separate weekday counter runs from 0 to 6 and is not tied to the date. The block is driven by a slow tick pulse: after `TICK_DIV` tick pulses it adds one second. Any carry then passes to the next field, one field per clock cycle, through a small state machine. The hour field holds a mode flag in bit 7. When the flag is 1 the hour counts 00–23. When it is 0 the hour counts 1–12, and bit 5 is the PM flag.

The host loads fields through a single-cycle write port that selects one field at a time. All fields can be read in parallel at all times.

The carry state machine has six states:
- **IDLE** waits for a due second. When one is due and there is no write, it adds one to the seconds.
- It moves to **MIN** when the seconds wrap from 59.
- **MIN** moves to **HOUR** when the minutes wrap.
- **HOUR** moves to **DATE** when the hour crosses midnight.
- **DATE** moves to **MON** when the day of month passes the last day of the month.
- **MON** moves to **YEAR** when the month wraps from 12.
- Every other outcome, and every write, returns the machine to **IDLE**.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the outputs are:
  - seconds 8'h00, minutes 8'h00, hour 8'h12 (12-hour mode, PM clear);
  - date 8'h01, month 8'h01, year 8'h00, weekday 0.
- R2: Seconds and minutes count in BCD from 00 to 59. A units digit of 9 goes to 0 with a carry into the tens digit. 59 wraps to 00 and carries into the next field.
- R3: With hour bit 7 = 1 (24-hour mode), the hour counts BCD 00–23 in bits 5:0. 23 wraps to 00 and advances the date.
- R4: With hour bit 7 = 0 (12-hour mode), the hour counts BCD 1–12 in bits 4:0 and bit 5 is the PM flag.
  - 11 AM goes to 12 PM.
  - 12 goes to 1 with the flag unchanged.
  - 11 PM goes to 12 AM and advances the date.
- R5: Months 4, 6, 9 and 11 end after day 30. Months 1, 3, 5, 7, 8, 10 and 12 end after day 31. After its last day a month rolls the date to 01 and advances the month.
- R6: February ends after day 29 when the BCD year is a multiple of 4, 00 included. Otherwise it ends after day 28.
- R7: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R8: The weekday counts 0,1,…,6,0 and advances exactly once each time the date advances.
- R9: A write takes priority over a tick in the same cycle. A write also clears the partial count of tick pulses, so the next second needs `TICK_DIV` new pulses.
- R10: `wr_sel_i` selects the field to load:
  - 0 seconds (bits 6:0 kept), 1 minutes (bits 6:0);
  - 2 hour (bit 6 forced 0), 3 date (bits 5:0), 4 month (bits 4:0);
  - 5 year (all bits), 6 weekday (bits 2:0).
  - Code 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Tick pulse, one cycle wide |
| wr_en_i | input | 1 | Write strobe for the selected field |
| wr_sel_i | input | 3 | Field select code |
| wr_data_i | input | 8 | Write data, BCD |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Bit 7 = 24-hour mode, bit 5 = PM (12-hour mode), BCD hour below |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |
| wday_o | output | 3 | Weekday 0–6 |

## Verification
The bench builds the block with `TICK_DIV` = 2, so each second takes two tick pulses. This makes the partial tick count visible at the ports. A single pulse followed by a write that collides with a second pulse must leave the seconds unchanged. It must then take two further pulses to advance them. With the default `TICK_DIV` of 1 there is no partial count to observe. `WEEK_DAYS` is kept at 7, so the weekday wrap from 6 to 0 is reached with one date rollover after the host loads 6.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_MIN  = 3'd1,
        ST_HOUR = 3'd2,
        ST_DATE = 3'd3,
        ST_MON  = 3'd4,
        ST_YEAR = 3'd5
    } rtc_state_e;

    typedef enum logic [2:0] {
        SEL_SEC   = 3'd0,
        SEL_MIN   = 3'd1,
        SEL_HOUR  = 3'd2,
        SEL_DATE  = 3'd3,
        SEL_MONTH = 3'd4,
        SEL_YEAR  = 3'd5,
        SEL_WDAY  = 3'd6,
        SEL_NONE  = 3'd7
    } rtc_field_e;

    // two-digit BCD increment; the units digit goes from 9 to 0 with a carry
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
    parameter int TICK_DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic clear_i,
    input  logic consume_i,
    output logic due_o
);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

    logic [CNT_W-1:0] sub_q;
    logic             pend_q;
    logic             last;

    assign last = (sub_q == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q  <= '0;
            pend_q <= 1'b0;
        end else if (clear_i) begin
            sub_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (tick_i) sub_q <= last ? '0 : sub_q + 1'b1;
            pend_q <= (pend_q & ~consume_i) | (tick_i & last);
        end
    end

    assign due_o = pend_q;
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step (
    input  logic       mode24_i,
    input  logic [5:0] hval_i,
    output logic [7:0] hour_nxt_o,
    output logic       day_carry_o
);
    import rtc_pkg::*;

    logic [7:0] inc24;
    logic [7:0] inc12;
    logic       pm;

    always_comb begin
        inc24 = bcd_inc({2'b00, hval_i});
        inc12 = bcd_inc({3'b000, hval_i[4:0]});
        pm    = hval_i[5];
        hour_nxt_o  = '0;
        day_carry_o = 1'b0;
        if (mode24_i) begin
            if (hval_i == 6'h23) begin
                hour_nxt_o  = 8'h80;
                day_carry_o = 1'b1;
            end else begin
                hour_nxt_o = {2'b10, inc24[5:0]};
            end
        end else begin
            if (hval_i[4:0] == 5'h11) begin
                hour_nxt_o  = {2'b00, ~pm, 5'h12};
                day_carry_o = pm;
            end else if (hval_i[4:0] == 5'h12) begin
                hour_nxt_o = {2'b00, pm, 5'h01};
            end else begin
                hour_nxt_o = {2'b00, pm, inc12[4:0]};
            end
        end
    end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
    input  logic [7:0] month_i,
    input  logic [7:0] year_i,
    output logic [7:0] last_o
);
    logic [3:0] mod_sum;
    logic       leap;

    // ten is 2 mod 4, so tens*10 + units is a multiple of 4 when 2*tens[0] + units is
    always_comb begin
        mod_sum = {2'b00, year_i[4], 1'b0} + year_i[3:0];
        leap    = (mod_sum[1:0] == 2'b00);
        unique case (month_i)
            8'h02:                      last_o = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_o = 8'h30;
            default:                    last_o = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar #(
    parameter int TICK_DIV  = 1,
    parameter int WEEK_DAYS = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_sel_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic [2:0] wday_o
);
    import rtc_pkg::*;

    localparam int WD_W = 3;
    localparam logic [WD_W-1:0] WD_LAST = WD_W'(WEEK_DAYS - 1);

    rtc_state_e state_q, state_d;

    logic [7:0]      sec_q, min_q, hour_q, date_q, month_q, year_q;
    logic [WD_W-1:0] wday_q;

    logic            due;
    logic            consume;
    logic [7:0]      sec_nxt, min_nxt, date_nxt, month_nxt, year_nxt;
    logic [WD_W-1:0] wday_nxt;
    logic            sec_wrap, min_wrap, date_wrap, month_wrap;
    logic [7:0]      hour_nxt;
    logic            hour_carry;
    logic [7:0]      month_last;

    assign consume = (state_q == ST_IDLE) && due && !wr_en_i;

    rtc_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .clear_i  (wr_en_i),
        .consume_i(consume),
        .due_o    (due)
    );

    rtc_hour_step u_hour (
        .mode24_i   (hour_q[7]),
        .hval_i     (hour_q[5:0]),
        .hour_nxt_o (hour_nxt),
        .day_carry_o(hour_carry)
    );

    rtc_month_len u_mlen (
        .month_i(month_q),
        .year_i (year_q),
        .last_o (month_last)
    );

    always_comb begin
        sec_wrap   = (sec_q == 8'h59);
        min_wrap   = (min_q == 8'h59);
        date_wrap  = (date_q == month_last);
        month_wrap = (month_q == 8'h12);
        sec_nxt    = sec_wrap   ? 8'h00 : bcd_inc(sec_q);
        min_nxt    = min_wrap   ? 8'h00 : bcd_inc(min_q);
        date_nxt   = date_wrap  ? 8'h01 : bcd_inc(date_q);
        month_nxt  = month_wrap ? 8'h01 : bcd_inc(month_q);
        year_nxt   = bcd_inc(year_q);
        if (year_q == 8'h99) year_nxt = 8'h00;
        wday_nxt   = (wday_q == WD_LAST) ? '0 : wday_q + 1'b1;
    end

    // next-state logic of the carry walker
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (due && sec_wrap) state_d = ST_MIN;
            ST_MIN:  state_d = min_wrap   ? ST_HOUR : ST_IDLE;
            ST_HOUR: state_d = hour_carry ? ST_DATE : ST_IDLE;
            ST_DATE: state_d = date_wrap  ? ST_MON  : ST_IDLE;
            ST_MON:  state_d = month_wrap ? ST_YEAR : ST_IDLE;
            ST_YEAR: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (wr_en_i) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // field registers: a host write wins over the walker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q   <= 8'h00;
            min_q   <= 8'h00;
            hour_q  <= 8'h12;
            date_q  <= 8'h01;
            month_q <= 8'h01;
            year_q  <= 8'h00;
            wday_q  <= '0;
        end else if (wr_en_i) begin
            case (rtc_field_e'(wr_sel_i))
                SEL_SEC:   sec_q   <= {1'b0, wr_data_i[6:0]};
                SEL_MIN:   min_q   <= {1'b0, wr_data_i[6:0]};
                SEL_HOUR:  hour_q  <= {wr_data_i[7], 1'b0, wr_data_i[5:0]};
                SEL_DATE:  date_q  <= {2'b00, wr_data_i[5:0]};
                SEL_MONTH: month_q <= {3'b000, wr_data_i[4:0]};
                SEL_YEAR:  year_q  <= wr_data_i;
                SEL_WDAY:  wday_q  <= wr_data_i[WD_W-1:0];
                default:   ;
            endcase
        end else begin
            unique case (state_q)
                ST_IDLE: if (due) sec_q <= sec_nxt;
                ST_MIN:  min_q <= min_nxt;
                ST_HOUR: hour_q <= hour_nxt;
                ST_DATE: begin
                    date_q <= date_nxt;
                    wday_q <= wday_nxt;
                end
                ST_MON:  month_q <= month_nxt;
                ST_YEAR: year_q <= year_nxt;
                default: ;
            endcase
        end
    end

    assign sec_o   = sec_q;
    assign min_o   = min_q;
    assign hour_o  = hour_q;
    assign date_o  = date_q;
    assign month_o = month_q;
    assign year_o  = year_q;
    assign wday_o  = wday_q;
endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
module rtc_bcd_calendar_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       wr_en_i,
    input logic [2:0] wr_sel_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [7:0] date_o,
    input logic [7:0] month_o,
    input logic [7:0] year_o,
    input logic [2:0] wday_o
);
    // R2
    sec_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en_i) && !$stable(sec_o)) |-> (sec_o[3:0] <= 4'd9));

    // R2
    min_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en_i) && !$stable(min_o)) |-> (min_o[3:0] <= 4'd9));

    // R4
    pm_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en_i) && !hour_o[7] && !$stable(hour_o[5])) |-> (hour_o[4:0] == 5'h12));

    // R7
    year_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en_i) && !$stable(year_o)) |-> (month_o == 8'h01));

    // R8
    wday_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en_i) && !$stable(wday_o)) |->
        (wday_o == (($past(wday_o) == 3'd6) ? 3'd0 : $past(wday_o) + 3'd1)));

    // R8
    wday_with_date_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en_i) && !$stable(wday_o)) |-> !$stable(date_o));

    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 3'd0 && tick_i) |=> (sec_o == {1'b0, $past(wr_data_i[6:0])}));
endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk u_chk (.*);

// File: tb/sim_rtc_bcd_calendar.sv
module sim_rtc_bcd_calendar;
    localparam int DIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] sec, min, hour, date, month, year;
    logic [2:0] wday;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_bcd_calendar #(.TICK_DIV(DIV), .WEEK_DAYS(7)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .sec_o(sec), .min_o(min), .hour_o(hour), .date_o(date),
        .month_o(month), .year_o(year), .wday_o(wday)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic settle();
        repeat (10) @(negedge clk);
    endtask

    task automatic one_second();
        for (int i = 0; i < DIV; i++) pulse();
        settle();
    endtask

    task automatic load(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                        input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
        wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
        wr(3'd3, d); wr(3'd4, mo); wr(3'd5, y);
    endtask

    task automatic t_reset();
        chk("R1 sec", sec, 8'h00);
        chk("R1 min", min, 8'h00);
        chk("R1 hour", hour, 8'h12);
        chk("R1 date", date, 8'h01);
        chk("R1 month", month, 8'h01);
        chk("R1 year", year, 8'h00);
        chk("R1 wday", {5'd0, wday}, 8'h00);
    endtask

    task automatic t_sec_min();
        load(8'h85, 8'h00, 8'h09, 8'h05, 8'h03, 8'h21);
        one_second();
        chk("R2 sec 09->10", sec, 8'h10);
        wr(3'd0, 8'h59); wr(3'd1, 8'h09);
        one_second();
        chk("R2 sec wrap", sec, 8'h00);
        chk("R2 min carry", min, 8'h10);
        wr(3'd0, 8'h59); wr(3'd1, 8'h59);
        one_second();
        chk("R2 min wrap", min, 8'h00);
        chk("R3 hour 05->06", hour, 8'h86);
    endtask

    task automatic t_24h();
        load(8'hA3, 8'h59, 8'h59, 8'h05, 8'h03, 8'h21);
        wr(3'd6, 8'h02);
        one_second();
        chk("R3 hour 23->00", hour, 8'h80);
        chk("R3 date carry", date, 8'h06);
        chk("R8 wday step", {5'd0, wday}, 8'h03);
    endtask

    task automatic t_12h();
        load(8'h11, 8'h59, 8'h59, 8'h10, 8'h03, 8'h21);
        one_second();
        chk("R4 11AM->12PM", hour, 8'h32);
        chk("R4 noon no date", date, 8'h10);
        wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        one_second();
        chk("R4 12PM->1PM", hour, 8'h21);
        load(8'h31, 8'h59, 8'h59, 8'h10, 8'h03, 8'h21);
        one_second();
        chk("R4 11PM->12AM", hour, 8'h12);
        chk("R4 midnight date", date, 8'h11);
    endtask

    task automatic t_month_len();
        load(8'hA3, 8'h59, 8'h59, 8'h30, 8'h04, 8'h21);
        one_second();
        chk("R5 apr30 date", date, 8'h01);
        chk("R5 apr30 month", month, 8'h05);
        load(8'hA3, 8'h59, 8'h59, 8'h30, 8'h05, 8'h21);
        one_second();
        chk("R5 may30 date", date, 8'h31);
        chk("R5 may30 month", month, 8'h05);
    endtask

    task automatic t_leap();
        load(8'hA3, 8'h59, 8'h59, 8'h28, 8'h02, 8'h24);
        one_second();
        chk("R6 y24 feb29", date, 8'h29);
        wr(3'd2, 8'hA3); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        one_second();
        chk("R6 y24 mar1 date", date, 8'h01);
        chk("R6 y24 mar1 month", month, 8'h03);
        load(8'hA3, 8'h59, 8'h59, 8'h28, 8'h02, 8'h23);
        one_second();
        chk("R6 y23 no leap", month, 8'h03);
        load(8'hA3, 8'h59, 8'h59, 8'h28, 8'h02, 8'h00);
        one_second();
        chk("R6 y00 leap", date, 8'h29);
        load(8'hA3, 8'h59, 8'h59, 8'h28, 8'h02, 8'h10);
        one_second();
        chk("R6 y10 no leap", date, 8'h01);
        load(8'hA3, 8'h59, 8'h59, 8'h28, 8'h02, 8'h12);
        one_second();
        chk("R6 y12 leap", date, 8'h29);
    endtask

    task automatic t_year();
        load(8'hA3, 8'h59, 8'h59, 8'h31, 8'h12, 8'h23);
        one_second();
        chk("R7 new year month", month, 8'h01);
        chk("R7 new year year", year, 8'h24);
        load(8'hA3, 8'h59, 8'h59, 8'h31, 8'h12, 8'h99);
        one_second();
        chk("R7 year 99->00", year, 8'h00);
        chk("R5 dec31 date", date, 8'h01);
    endtask

    task automatic t_wday();
        load(8'hA3, 8'h59, 8'h59, 8'h07, 8'h06, 8'h21);
        wr(3'd6, 8'h06);
        one_second();
        chk("R8 wday 6->0", {5'd0, wday}, 8'h00);
        one_second();
        chk("R8 wday held", {5'd0, wday}, 8'h00);
    endtask

    task automatic t_priority();
        wr(3'd0, 8'h10);
        pulse();
        settle();
        chk("R9 half second", sec, 8'h10);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h20; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        settle();
        chk("R9 write wins", sec, 8'h20);
        pulse();
        settle();
        chk("R9 count cleared", sec, 8'h20);
        pulse();
        settle();
        chk("R9 full second", sec, 8'h21);
    endtask

    task automatic t_select();
        load(8'h05, 8'h30, 8'h40, 8'h15, 8'h07, 8'h33);
        wr(3'd7, 8'h55);
        chk("R10 sel7 sec", sec, 8'h40);
        chk("R10 sel7 min", min, 8'h30);
        chk("R10 sel7 date", date, 8'h15);
        chk("R10 sel7 year", year, 8'h33);
        wr(3'd2, 8'h45);
        chk("R10 hour bit6", hour, 8'h05);
        wr(3'd4, 8'hE9);
        chk("R10 month mask", month, 8'h09);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sec_min();
        t_24h();
        t_12h();
        t_month_len();
        t_leap();
        t_year();
        t_wday();
        t_priority();
        t_select();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule